// File: doc/BRIEF.md
# Debug Event Qualifier for Breakpoint and Watchpoint Comparators

This block sits behind a set of hardware debug comparators and decides whether a candidate hit becomes a real debug event. There are `NSLOT` instruction-address comparators (breakpoints) and `NSLOT` data comparators (watchpoints). For a watchpoint slot, the address match is done upstream and arrives as one raw-hit bit per slot. A breakpoint slot compares its own stored address with the current program counter.

Each candidate is then filtered in four ways:
- by the security state the slot is restricted to;
- by a privilege mask chosen by the current exception level;
- by an optional link to a context-aware breakpoint slot, which in turn compares its value against the current context identifier;
- by a global monitor enable together with a "debug exceptions permitted" condition.

On a one-cycle request strobe the block scans every slot of the selected kind in parallel. One cycle later it presents:
- whether any slot qualified;
- the index of the lowest-numbered qualifying slot;
- the fault-status code that the exception logic reports for a debug event.

Top module: `dbg_hit_qual`

## Requirements
- R1: When `mon_en_i` is 0 or `excp_ok_i` is 0, a request never reports a hit.
- R2: The security field of a control word (bits [15:14]) selects where the slot may match. Value 0 matches in both states, values 1 and 3 match only when `secure_i` is 0, and value 2 matches only when `secure_i` is 1.
- R3: The privilege check depends on the level used for the access. At level 2 or 3 it needs control bit 13. At level 1 it needs control bit 1, the low bit of the mask in bits [2:1]. At level 0 it needs control bit 2.
- R4: For a watchpoint request with `wp_unpriv_i` set, the privilege check uses level 0, whatever `cur_el_i` is.
- R5: A breakpoint slot is a candidate only when its enable bit 0 is set and its 64-bit value equals `pc_i`.
- R6: When link enable (control bit 20) is set, the linked index in bits [19:16] must lie in the range from `BRP_LAST-CTX_CMPS` to `BRP_LAST`. Any other index makes the slot fail. With the defaults that range is 2..3.
- R7: A linked breakpoint slot fails if its enable bit 0 is clear, or if its type field in bits [23:20] is not 3.
- R8: A linked type-3 slot passes only when `cur_el_i` is at most 1 and the low 32 bits of its value equal `ctx_id_i`.
- R9: When several slots qualify, the lowest-numbered one is reported in `hit_idx_o`.
- R10: A hit reports `fsr_o` = 0x0222 when `long_fmt_i` is 1 and 0x0002 otherwise.
- R11: Outputs change only in the cycle after `req_i`. `done_o` pulses for exactly that cycle, and the other outputs hold until the next request. After reset, and after a request with no hit, `hit_o`, `hit_idx_o` and `fsr_o` are 0.
- R12: A watchpoint slot can hit only when its bit of `wp_hit_i` is set. Breakpoint state plays no part in a watchpoint request (`is_watch_i`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Evaluation strobe |
| is_watch_i | input | 1 | 1 = evaluate the watchpoint slots, 0 = the breakpoint slots |
| mon_en_i | input | 1 | Global debug monitor enable |
| excp_ok_i | input | 1 | Debug exceptions are currently permitted |
| cur_el_i | input | 2 | Current exception level |
| secure_i | input | 1 | Current security state (1 = secure) |
| wp_unpriv_i | input | 1 | The watched access was an unprivileged load/store |
| wp_hit_i | input | NSLOT | Upstream address match for each watchpoint slot |
| bp_ctrl_i | input | NSLOT*64 | Breakpoint control words, slot 0 in the low bits |
| bp_val_i | input | NSLOT*64 | Breakpoint value words (address or context ID) |
| wp_ctrl_i | input | NSLOT*64 | Watchpoint control words |
| pc_i | input | 64 | Current program counter |
| ctx_id_i | input | 32 | Current context identifier |
| long_fmt_i | input | 1 | Long-descriptor fault format in use |
| done_o | output | 1 | Result valid, one cycle after `req_i` |
| hit_o | output | 1 | A slot qualified |
| hit_idx_o | output | IDX_W | Lowest qualifying slot |
| fsr_o | output | 16 | Fault-status code of the event |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the one-cycle response pulse and the holding of results between requests;
- the gating by the monitor enable and the permission input;
- the fault code tied to the captured format bit;
- the all-zero result of a miss;
- the rule that a watchpoint hit points at a slot whose raw hit was set.

Other behaviours depend on the contents of the control words, so only the bench's directed scenarios can show them:
- the security and privilege filtering;
- the level-0 treatment of unprivileged watched accesses;
- the range, enable, type and context rules of the link;
- the lowest-index priority.

// File: rtl/dbg_qual_pkg.sv
package dbg_qual_pkg;

    localparam int CTL_W   = 64;
    localparam int LBN_W   = 4;
    localparam int FSR_W   = 16;

    localparam logic [3:0]       TYPE_CTX_LINK = 4'd3;
    localparam logic [FSR_W-1:0] FSR_LONG      = 16'h0222;
    localparam logic [FSR_W-1:0] FSR_SHORT     = 16'h0002;

    typedef struct packed {
        logic             link;
        logic [LBN_W-1:0] lbn;
        logic [1:0]       sec;
        logic             hmc;
        logic [1:0]       pmask;
        logic             en;
    } slot_ctl_t;

    function automatic slot_ctl_t decode_ctl(input logic [CTL_W-1:0] w);
        slot_ctl_t c;
        c.en    = w[0];
        c.pmask = w[2:1];
        c.hmc   = w[13];
        c.sec   = w[15:14];
        c.lbn   = w[19:16];
        c.link  = w[20];
        return c;
    endfunction

    function automatic logic [3:0] ctl_type(input logic [CTL_W-1:0] w);
        return w[23:20];
    endfunction

endpackage

// File: rtl/dbg_ctx_link.sv
module dbg_ctx_link
    import dbg_qual_pkg::*;
#(
    parameter int NSLOT    = 4,
    parameter int BRP_LAST = NSLOT - 1,
    parameter int CTX_CMPS = 1,
    parameter int CID_W    = 32,
    localparam int NLINK   = 1 << LBN_W
) (
    input  logic [NSLOT*CTL_W-1:0] bp_ctrl_i,
    input  logic [NSLOT*CTL_W-1:0] bp_val_i,
    input  logic [1:0]             cur_el_i,
    input  logic [CID_W-1:0]       ctx_id_i,
    output logic [NLINK-1:0]       ctx_pass_o
);

    localparam int LOW_CTX = BRP_LAST - CTX_CMPS;

    for (genvar i = 0; i < NLINK; i++) begin : g_link
        if (i < NSLOT && i <= BRP_LAST && i >= LOW_CTX) begin : g_impl
            logic [CTL_W-1:0] ctl_w;
            logic [CTL_W-1:0] val_w;
            assign ctl_w = bp_ctrl_i[i*CTL_W +: CTL_W];
            assign val_w = bp_val_i[i*CTL_W +: CTL_W];
            always_comb begin
                ctx_pass_o[i] = ctl_w[0]
                              && (ctl_type(ctl_w) == TYPE_CTX_LINK)
                              && (cur_el_i <= 2'd1)
                              && (val_w[CID_W-1:0] == ctx_id_i);
            end
        end else begin : g_absent
            assign ctx_pass_o[i] = 1'b0;
        end
    end

endmodule

// File: rtl/dbg_slot_qual.sv
module dbg_slot_qual
    import dbg_qual_pkg::*;
#(
    localparam int NLINK = 1 << LBN_W
) (
    input  logic [CTL_W-1:0] ctl_i,
    input  logic             raw_hit_i,
    input  logic [1:0]       acc_el_i,
    input  logic             secure_i,
    input  logic [NLINK-1:0] ctx_pass_i,
    output logic             qual_o
);

    slot_ctl_t c;
    logic      sec_ok;
    logic      priv_ok;
    logic      link_ok;

    always_comb begin
        c = decode_ctl(ctl_i);

        unique case (c.sec)
            2'd0:    sec_ok = 1'b1;
            2'd2:    sec_ok = secure_i;
            default: sec_ok = !secure_i;
        endcase

        unique case (acc_el_i)
            2'd0:    priv_ok = c.pmask[1];
            2'd1:    priv_ok = c.pmask[0];
            default: priv_ok = c.hmc;
        endcase

        link_ok = !c.link || ctx_pass_i[c.lbn];
        qual_o  = raw_hit_i && sec_ok && priv_ok && link_ok;
    end

endmodule

// File: rtl/dbg_prio_pick.sv
module dbg_prio_pick #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     cand_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/dbg_hit_qual.sv
module dbg_hit_qual
    import dbg_qual_pkg::*;
#(
    parameter int NSLOT    = 4,
    parameter int BRP_LAST = NSLOT - 1,
    parameter int CTX_CMPS = 1,
    parameter int PC_W     = 64,
    parameter int CID_W    = 32,
    localparam int IDX_W   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_i,
    input  logic                   is_watch_i,
    input  logic                   mon_en_i,
    input  logic                   excp_ok_i,
    input  logic [1:0]             cur_el_i,
    input  logic                   secure_i,
    input  logic                   wp_unpriv_i,
    input  logic [NSLOT-1:0]       wp_hit_i,
    input  logic [NSLOT*CTL_W-1:0] bp_ctrl_i,
    input  logic [NSLOT*CTL_W-1:0] bp_val_i,
    input  logic [NSLOT*CTL_W-1:0] wp_ctrl_i,
    input  logic [PC_W-1:0]        pc_i,
    input  logic [CID_W-1:0]       ctx_id_i,
    input  logic                   long_fmt_i,
    output logic                   done_o,
    output logic                   hit_o,
    output logic [IDX_W-1:0]       hit_idx_o,
    output logic [FSR_W-1:0]       fsr_o
);

    localparam int NLINK = 1 << LBN_W;

    typedef struct packed {
        logic             done;
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic [FSR_W-1:0] fsr;
    } res_t;

    res_t res_d, res_q;

    logic [NLINK-1:0] ctx_pass;
    logic [NSLOT-1:0] bp_qual;
    logic [NSLOT-1:0] wp_qual;
    logic [NSLOT-1:0] cand;
    logic [1:0]       wp_el;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;

    dbg_ctx_link #(
        .NSLOT    (NSLOT),
        .BRP_LAST (BRP_LAST),
        .CTX_CMPS (CTX_CMPS),
        .CID_W    (CID_W)
    ) u_link (
        .bp_ctrl_i  (bp_ctrl_i),
        .bp_val_i   (bp_val_i),
        .cur_el_i   (cur_el_i),
        .ctx_id_i   (ctx_id_i),
        .ctx_pass_o (ctx_pass)
    );

    assign wp_el = wp_unpriv_i ? 2'd0 : cur_el_i;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic [CTL_W-1:0] bctl;
        logic [CTL_W-1:0] bval;
        logic             b_raw;
        assign bctl  = bp_ctrl_i[s*CTL_W +: CTL_W];
        assign bval  = bp_val_i[s*CTL_W +: CTL_W];
        assign b_raw = bctl[0] && (bval[PC_W-1:0] == pc_i);

        dbg_slot_qual u_bp (
            .ctl_i      (bctl),
            .raw_hit_i  (b_raw),
            .acc_el_i   (cur_el_i),
            .secure_i   (secure_i),
            .ctx_pass_i (ctx_pass),
            .qual_o     (bp_qual[s])
        );

        dbg_slot_qual u_wp (
            .ctl_i      (wp_ctrl_i[s*CTL_W +: CTL_W]),
            .raw_hit_i  (wp_hit_i[s]),
            .acc_el_i   (wp_el),
            .secure_i   (secure_i),
            .ctx_pass_i (ctx_pass),
            .qual_o     (wp_qual[s])
        );
    end

    assign cand = (mon_en_i && excp_ok_i) ? (is_watch_i ? wp_qual : bp_qual) : '0;

    dbg_prio_pick #(
        .N     (NSLOT),
        .IDX_W (IDX_W)
    ) u_pick (
        .cand_i (cand),
        .any_o  (pick_any),
        .idx_o  (pick_idx)
    );

    always_comb begin
        res_d      = res_q;
        res_d.done = 1'b0;
        if (req_i) begin
            res_d.done = 1'b1;
            res_d.hit  = pick_any;
            res_d.idx  = pick_any ? pick_idx : '0;
            res_d.fsr  = pick_any ? (long_fmt_i ? FSR_LONG : FSR_SHORT) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign done_o    = res_q.done;
    assign hit_o     = res_q.hit;
    assign hit_idx_o = res_q.idx;
    assign fsr_o     = res_q.fsr;

    p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && !(mon_en_i && excp_ok_i) |=> !hit_o);

    p_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> done_o);

    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !done_o && $stable(hit_o) && $stable(hit_idx_o) && $stable(fsr_o));

    p_miss_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !hit_o |-> hit_idx_o == '0 && fsr_o == '0);

    p_fsr_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && hit_o |-> fsr_o == ($past(long_fmt_i) ? FSR_LONG : FSR_SHORT));

    p_watch_raw_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && hit_o && $past(is_watch_i)
            |-> ($past(wp_hit_i) & (NSLOT'(1) << hit_idx_o)) != '0);

endmodule

// File: tb/dbg_hit_qual_tb.sv
module dbg_hit_qual_tb;

    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0;
    logic          is_watch_i, mon_en_i, excp_ok_i, secure_i, wp_unpriv_i, long_fmt_i;
    logic [1:0]    cur_el_i;
    logic [NS-1:0] wp_hit_i;
    logic [63:0]   bpc [NS];
    logic [63:0]   bpv [NS];
    logic [63:0]   wpc [NS];
    logic [NS*64-1:0] bp_ctrl_i, bp_val_i, wp_ctrl_i;
    logic [63:0]   pc_i;
    logic [31:0]   ctx_id_i;
    logic          done_o, hit_o;
    logic [1:0]    hit_idx_o;
    logic [15:0]   fsr_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign bp_ctrl_i = {bpc[3], bpc[2], bpc[1], bpc[0]};
    assign bp_val_i  = {bpv[3], bpv[2], bpv[1], bpv[0]};
    assign wp_ctrl_i = {wpc[3], wpc[2], wpc[1], wpc[0]};

    dbg_hit_qual u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .is_watch_i(is_watch_i),
        .mon_en_i(mon_en_i), .excp_ok_i(excp_ok_i), .cur_el_i(cur_el_i),
        .secure_i(secure_i), .wp_unpriv_i(wp_unpriv_i), .wp_hit_i(wp_hit_i),
        .bp_ctrl_i(bp_ctrl_i), .bp_val_i(bp_val_i), .wp_ctrl_i(wp_ctrl_i),
        .pc_i(pc_i), .ctx_id_i(ctx_id_i), .long_fmt_i(long_fmt_i),
        .done_o(done_o), .hit_o(hit_o), .hit_idx_o(hit_idx_o), .fsr_o(fsr_o)
    );

    localparam logic [63:0] PC0  = 64'h0000_0000_0000_1000;
    localparam logic [31:0] CTX0 = 32'h0000_0055;

    // en bit0, mask [2:1], higher-mode bit13, security [15:14], link idx [19:16], link bit20
    function automatic logic [63:0] mk(input logic en, input logic [1:0] pm, input logic hm,
                                       input logic [1:0] sc, input logic [3:0] lbn,
                                       input logic lk);
        logic [63:0] w = '0;
        w[0] = en; w[2:1] = pm; w[13] = hm; w[15:14] = sc; w[19:16] = lbn; w[20] = lk;
        return w;
    endfunction

    function automatic logic [63:0] mk_ctx(input logic en, input logic [3:0] typ);
        logic [63:0] w = '0;
        w[0] = en; w[23:20] = typ;
        return w;
    endfunction

    task automatic clear();
        for (int i = 0; i < NS; i++) begin bpc[i] = '0; bpv[i] = '0; wpc[i] = '0; end
        is_watch_i = 0; mon_en_i = 1; excp_ok_i = 1; secure_i = 0; wp_unpriv_i = 0;
        long_fmt_i = 0; cur_el_i = 2'd1; wp_hit_i = '0; pc_i = PC0; ctx_id_i = CTX0;
    endtask

    task automatic fire();
        @(negedge clk) req_i = 1'b1;
        @(negedge clk) req_i = 1'b0;
    endtask

    task automatic chk(input string tag, input logic eh, input int ei, input logic [15:0] ef);
        n_chk++;
        if (done_o !== 1'b1 || hit_o !== eh || hit_idx_o !== 2'(ei) || fsr_o !== ef) begin
            n_bad++;
            $display("FAIL %s: got done=%0b hit=%0b idx=%0d fsr=%h, expected done=1 hit=%0b idx=%0d fsr=%h",
                     tag, done_o, hit_o, hit_idx_o, fsr_o, eh, ei, ef);
        end
    endtask

    task automatic t_reset();
        n_chk++;
        if (done_o !== 0 || hit_o !== 0 || hit_idx_o !== 0 || fsr_o !== 0) begin
            n_bad++;
            $display("FAIL R11 reset: got %0b %0b %0d %h, expected all 0", done_o, hit_o, hit_idx_o, fsr_o);
        end
    endtask

    task automatic t_basic();
        clear();
        bpc[1] = mk(1, 2'b01, 0, 0, 0, 0); bpv[1] = PC0;
        fire(); chk("R5 bp hit", 1, 1, 16'h0002);
        long_fmt_i = 1;
        fire(); chk("R10 long code", 1, 1, 16'h0222);
        long_fmt_i = 0; pc_i = PC0 + 4;
        fire(); chk("R5 pc mismatch", 0, 0, 16'h0);
        pc_i = PC0; bpc[1][0] = 1'b0;
        fire(); chk("R5 disabled", 0, 0, 16'h0);
    endtask

    task automatic t_gate();
        clear();
        bpc[0] = mk(1, 2'b01, 0, 0, 0, 0); bpv[0] = PC0;
        mon_en_i = 0; fire(); chk("R1 monitor off", 0, 0, 16'h0);
        mon_en_i = 1; excp_ok_i = 0; fire(); chk("R1 not permitted", 0, 0, 16'h0);
    endtask

    task automatic t_security();
        clear();
        bpc[0] = mk(1, 2'b01, 0, 2'd2, 0, 0); bpv[0] = PC0;
        fire(); chk("R2 sc2 nonsecure", 0, 0, 16'h0);
        secure_i = 1; fire(); chk("R2 sc2 secure", 1, 0, 16'h0002);
        bpc[0] = mk(1, 2'b01, 0, 2'd3, 0, 0);
        fire(); chk("R2 sc3 secure", 0, 0, 16'h0);
        secure_i = 0; fire(); chk("R2 sc3 nonsecure", 1, 0, 16'h0002);
        secure_i = 1; bpc[0] = mk(1, 2'b01, 0, 2'd0, 0, 0);
        fire(); chk("R2 sc0 secure", 1, 0, 16'h0002);
    endtask

    task automatic t_priv();
        clear();
        bpc[2] = mk(1, 2'b01, 0, 0, 0, 0); bpv[2] = PC0;
        cur_el_i = 0; fire(); chk("R3 el0 mask01", 0, 0, 16'h0);
        bpc[2] = mk(1, 2'b10, 0, 0, 0, 0);
        fire(); chk("R3 el0 mask10", 1, 2, 16'h0002);
        cur_el_i = 2; bpc[2] = mk(1, 2'b11, 0, 0, 0, 0);
        fire(); chk("R3 el2 no hm", 0, 0, 16'h0);
        cur_el_i = 3; bpc[2] = mk(1, 2'b00, 1, 0, 0, 0);
        fire(); chk("R3 el3 hm", 1, 2, 16'h0002);
    endtask

    task automatic t_watch();
        clear();
        is_watch_i = 1;
        wpc[1] = mk(1, 2'b01, 0, 0, 0, 0);
        bpc[0] = mk(1, 2'b01, 0, 0, 0, 0); bpv[0] = PC0;
        fire(); chk("R12 no raw hit", 0, 0, 16'h0);
        wp_hit_i = 4'b0010;
        fire(); chk("R12 raw hit", 1, 1, 16'h0002);
        wp_unpriv_i = 1;
        fire(); chk("R4 unpriv uses el0", 0, 0, 16'h0);
        wpc[1] = mk(1, 2'b10, 0, 0, 0, 0);
        fire(); chk("R4 unpriv mask10", 1, 1, 16'h0002);
    endtask

    task automatic t_link();
        clear();
        bpc[0] = mk(1, 2'b01, 0, 0, 4'd3, 1); bpv[0] = PC0;
        bpc[3] = mk_ctx(1, 4'd3); bpv[3] = {32'h0, CTX0};
        fire(); chk("R8 ctx match", 1, 0, 16'h0002);
        ctx_id_i = CTX0 + 1; fire(); chk("R8 ctx mismatch", 0, 0, 16'h0);
        ctx_id_i = CTX0; cur_el_i = 2; bpc[0][13] = 1'b1;
        fire(); chk("R8 el2 blocks ctx", 0, 0, 16'h0);
        cur_el_i = 1; bpc[3] = mk_ctx(0, 4'd3);
        fire(); chk("R7 linked disabled", 0, 0, 16'h0);
        bpc[3] = mk_ctx(1, 4'd5);
        fire(); chk("R7 linked type5", 0, 0, 16'h0);
        bpc[1] = mk_ctx(1, 4'd3); bpv[1] = {32'h0, CTX0};
        bpc[0] = mk(1, 2'b01, 0, 0, 4'd1, 1);
        fire(); chk("R6 index below range", 0, 0, 16'h0);
        bpc[0] = mk(1, 2'b01, 0, 0, 4'd5, 1);
        fire(); chk("R6 index above range", 0, 0, 16'h0);
        bpc[2] = mk_ctx(1, 4'd3); bpv[2] = {32'h0, CTX0};
        bpc[0] = mk(1, 2'b01, 0, 0, 4'd2, 1);
        fire(); chk("R6 index at low end", 1, 0, 16'h0002);
    endtask

    task automatic t_prio();
        clear();
        bpc[1] = mk(1, 2'b01, 0, 0, 0, 0); bpv[1] = PC0;
        bpc[2] = mk(1, 2'b01, 0, 0, 0, 0); bpv[2] = PC0;
        fire(); chk("R9 bp lowest", 1, 1, 16'h0002);
        is_watch_i = 1; wp_hit_i = 4'b1001;
        wpc[0] = mk(1, 2'b01, 0, 0, 0, 0); wpc[3] = mk(1, 2'b01, 0, 0, 0, 0);
        fire(); chk("R9 wp lowest", 1, 0, 16'h0002);
        @(negedge clk);
        n_chk++;
        if (done_o !== 0 || hit_o !== 1 || hit_idx_o !== 0) begin
            n_bad++;
            $display("FAIL R11 hold: got done=%0b hit=%0b idx=%0d, expected done=0 hit=1 idx=0",
                     done_o, hit_o, hit_idx_o);
        end
    endtask

    initial begin
        clear();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_gate();
        t_security();
        t_priv();
        t_watch();
        t_link();
        t_prio();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got no completion, expected end of scenarios");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule